// File: doc/BRIEF.md
# Ethernet Frame Synchronizer and Byte Assembler

This block sits behind a clock-recovery stage on a 10 Mb/s Ethernet receive path. It takes one recovered line bit at a time, qualified by a bit strobe, plus a carrier-present level. While carrier is present it looks for the synchronization run: a stretch of strictly alternating bits ending in two consecutive ones. Once it has locked, it packs every following bit into bytes, first-received bit in bit 0.

Each completed byte leaves as a one-cycle strobe. The first byte of a frame carries a start flag. When carrier goes away during a frame, an end-of-frame pulse is produced, together with a flag saying whether the frame ended in the middle of a byte. The frame check sequence is not checked here. Its bytes come out like any other payload byte, so the output can be loaded directly into a serial-peripheral shift register.

Lock needs far fewer than the nominal 62 alternating bits. This tolerates preamble bits that are lost while the upstream clock recovery settles.

Top module: `rx_sync_deser`

## Requirements
- R1: During and after synchronous active-high reset, `byte_vld_o`, `sof_o`, `eof_o`, `align_err_o` and `byte_o` are all zero until a frame is received.
- R2: The block locks when two consecutive ones arrive and the strictly alternating stretch ending in the first of those ones is at least MIN_ALT (default 8) bits long. The very next strobed bit is data bit 0 of byte 0.
- R3: If the two ones arrive after an alternating stretch shorter than MIN_ALT, the block does not lock, and no byte or end-of-frame pulse follows.
- R4: Two consecutive zeros before lock send the block back to the hunt state, and the second zero is discarded. A later stretch of alternating bits can still lock within the same carrier period.
- R5: After lock, every eighth strobed bit produces exactly one `byte_vld_o` pulse one cycle long. In `byte_o`, bit 0 is the earliest of the eight bits. Trailing check-sequence bytes are emitted the same way.
- R6: `sof_o` is high together with `byte_vld_o` for the first byte of each frame only.
- R7: When `crs_i` falls after lock, `eof_o` pulses for exactly one cycle, exactly once per frame. `align_err_o` is low when a whole number of bytes was received.
- R8: If carrier falls after 1 to 7 bits of an unfinished byte, `align_err_o` is high with `eof_o` and the partial byte is not emitted.
- R9: Bit strobes are ignored while `crs_i` is low. A carrier drop before lock produces no end-of-frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_bit_i | input | 1 | Recovered line bit |
| bit_stb_i | input | 1 | Marks `line_bit_i` valid for this cycle |
| crs_i | input | 1 | Carrier present |
| byte_o | output | DATA_W | Assembled byte, first bit in bit 0 |
| byte_vld_o | output | 1 | One-cycle strobe for `byte_o` |
| sof_o | output | 1 | First byte of the frame, valid with `byte_vld_o` |
| eof_o | output | 1 | One-cycle end-of-frame pulse |
| align_err_o | output | 1 | Frame ended on a partial byte, valid with `eof_o` |

## Verification
If the lock tracker counts wrong, the fault shows on the first frame. The byte strobes are missing, or they appear for a preamble that is too short, and the bytes come out shifted by one or more bits. If the bit counter is wrong, the fault shows within eight strobed bits: the byte strobe lands at the wrong spacing and `align_err_o` disagrees with the number of trailing bits. A stuck frame-state register shows one cycle after carrier drops, as a missing or repeated `eof_o`, or as a missing `sof_o` on the next frame.

// File: rtl/rx_sync_pkg.sv
package rx_sync_pkg;

    localparam int DEF_DATA_W  = 8;
    localparam int DEF_MIN_ALT = 8;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2,
        ST_END  = 2'd3
    } rx_state_t;

    typedef enum logic [1:0] {
        EV_START = 2'd0,
        EV_ALT   = 2'd1,
        EV_SYNC  = 2'd2,
        EV_BREAK = 2'd3
    } pre_evt_t;

    typedef struct packed {
        logic vld;
        logic sof;
        logic eof;
        logic aerr;
    } rx_flags_t;

    function automatic pre_evt_t classify(input logic run_zero, input logic run_ok,
                                          input logic last, input logic b);
        if (run_zero)
            return EV_START;
        else if (b != last)
            return EV_ALT;
        else if (b && run_ok)
            return EV_SYNC;
        else
            return EV_BREAK;
    endfunction

endpackage

// File: rtl/rx_pre_track.sv
module rx_pre_track
    import rx_sync_pkg::*;
#(
    parameter int MIN_ALT = DEF_MIN_ALT
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     step,
    input  logic     bit_i,
    output pre_evt_t evt_o
);
    localparam int RUN_W = $clog2(MIN_ALT + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_ALT);

    logic [RUN_W-1:0] run_q;
    logic             last_q;

    assign evt_o = classify(run_q == '0, run_q >= RUN_MAX, last_q, bit_i);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q  <= '0;
            last_q <= 1'b0;
        end else if (step) begin
            unique case (evt_o)
                EV_START, EV_ALT: begin
                    last_q <= bit_i;
                    if (run_q != RUN_MAX)
                        run_q <= run_q + 1'b1;
                end
                default: begin
                    run_q  <= '0;
                    last_q <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/rx_byte_pack.sv
module rx_byte_pack #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift,
    input  logic              bit_i,
    output logic [DATA_W-1:0] word_o,
    output logic              done_o,
    output logic              part_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    assign word_o = {bit_i, sh_q[DATA_W-1:1]};
    assign done_o = shift && (cnt_q == CNT_LAST);
    assign part_o = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shift) begin
            sh_q  <= word_o;
            cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rx_sync_deser.sv
module rx_sync_deser
    import rx_sync_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int MIN_ALT = DEF_MIN_ALT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_bit_i,
    input  logic              bit_stb_i,
    input  logic              crs_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              sof_o,
    output logic              eof_o,
    output logic              align_err_o
);
    rx_state_t         st_q;
    rx_flags_t         fl_q;
    logic [DATA_W-1:0] byte_q;
    logic              first_q;

    logic              take;
    logic              trk_step;
    logic              trk_clr;
    pre_evt_t          evt;
    logic              pk_shift;
    logic              pk_clr;
    logic [DATA_W-1:0] pk_word;
    logic              pk_done;
    logic              pk_part;

    assign take     = bit_stb_i && crs_i;
    assign trk_step = take && (st_q == ST_HUNT || st_q == ST_PRE);
    assign trk_clr  = !crs_i || st_q == ST_DATA || st_q == ST_END;
    assign pk_shift = take && st_q == ST_DATA;
    assign pk_clr   = st_q != ST_DATA;

    rx_pre_track #(.MIN_ALT(MIN_ALT)) u_trk (
        .clk   (clk),
        .rst   (rst),
        .clr   (trk_clr),
        .step  (trk_step),
        .bit_i (line_bit_i),
        .evt_o (evt)
    );

    rx_byte_pack #(.DATA_W(DATA_W)) u_pack (
        .clk    (clk),
        .rst    (rst),
        .clr    (pk_clr),
        .shift  (pk_shift),
        .bit_i  (line_bit_i),
        .word_o (pk_word),
        .done_o (pk_done),
        .part_o (pk_part)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_HUNT;
            fl_q    <= '0;
            byte_q  <= '0;
            first_q <= 1'b0;
        end else begin
            fl_q <= '0;
            unique case (st_q)
                ST_HUNT: begin
                    if (trk_step && evt == EV_START)
                        st_q <= ST_PRE;
                end
                ST_PRE: begin
                    if (!crs_i)
                        st_q <= ST_HUNT;
                    else if (trk_step) begin
                        if (evt == EV_SYNC) begin
                            st_q    <= ST_DATA;
                            first_q <= 1'b1;
                        end else if (evt == EV_BREAK) begin
                            st_q <= ST_HUNT;
                        end
                    end
                end
                ST_DATA: begin
                    if (!crs_i) begin
                        st_q      <= ST_END;
                        fl_q.eof  <= 1'b1;
                        fl_q.aerr <= pk_part;
                    end else if (pk_done) begin
                        byte_q   <= pk_word;
                        fl_q.vld <= 1'b1;
                        fl_q.sof <= first_q;
                        first_q  <= 1'b0;
                    end
                end
                default: st_q <= ST_HUNT;
            endcase
        end
    end

    assign byte_o      = byte_q;
    assign byte_vld_o  = fl_q.vld;
    assign sof_o       = fl_q.sof;
    assign eof_o       = fl_q.eof;
    assign align_err_o = fl_q.aerr;
endmodule

// File: rtl/rx_sync_checker.sv
module rx_sync_checker (
    input logic clk,
    input logic rst,
    input logic bit_stb_i,
    input logic crs_i,
    input logic byte_vld_o,
    input logic sof_o,
    input logic eof_o,
    input logic align_err_o
);
    // R1: outputs quiet in the cycle after a reset cycle
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!byte_vld_o && !sof_o && !eof_o && !align_err_o));

    // R5: a byte strobe never lasts two cycles
    assert_vld_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |=> !byte_vld_o);

    // R6: start flag only on a byte strobe
    assert_sof_on_byte_R6: assert property (@(posedge clk) disable iff (rst)
        sof_o |-> byte_vld_o);

    // R7: end pulse is one cycle and follows a cycle without carrier
    assert_eof_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        eof_o |=> !eof_o);
    assert_eof_after_drop_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(eof_o) |-> !$past(crs_i));

    // R8: alignment flag only with the end pulse
    assert_aerr_with_eof_R8: assert property (@(posedge clk) disable iff (rst)
        align_err_o |-> eof_o);

    // R9: a byte is only completed by a strobed bit under carrier
    assert_byte_needs_carrier_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(byte_vld_o) |-> $past(crs_i && bit_stb_i));

    // R5/R7: byte strobe and end pulse never coincide
    assert_vld_eof_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(byte_vld_o && eof_o));
endmodule

bind rx_sync_deser rx_sync_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_stb_i   (bit_stb_i),
    .crs_i       (crs_i),
    .byte_vld_o  (byte_vld_o),
    .sof_o       (sof_o),
    .eof_o       (eof_o),
    .align_err_o (align_err_o)
);

// File: tb/sim_rx_sync_deser.sv
module sim_rx_sync_deser;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_bit_i = 1'b0;
    logic       bit_stb_i = 1'b0;
    logic       crs_i = 1'b0;
    logic [7:0] byte_o;
    logic       byte_vld_o, sof_o, eof_o, align_err_o;

    int checks = 0;
    int failures = 0;

    logic [7:0] got_b   [0:63];
    logic       got_sof [0:63];
    int         n_got = 0;
    int         n_eof = 0;
    logic       last_aerr = 1'b0;
    logic [7:0] exp_b   [0:63];
    int         cycles = 0;

    always #2 clk = ~clk;

    rx_sync_deser u0 (
        .clk(clk), .rst(rst), .line_bit_i(line_bit_i), .bit_stb_i(bit_stb_i),
        .crs_i(crs_i), .byte_o(byte_o), .byte_vld_o(byte_vld_o), .sof_o(sof_o),
        .eof_o(eof_o), .align_err_o(align_err_o)
    );

    always @(negedge clk) begin
        if (byte_vld_o && n_got < 64) begin
            got_b[n_got]   = byte_o;
            got_sof[n_got] = sof_o;
            n_got          = n_got + 1;
        end
        if (eof_o) begin
            n_eof     = n_eof + 1;
            last_aerr = align_err_o;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        line_bit_i = b;
        bit_stb_i  = 1'b1;
        @(negedge clk);
        bit_stb_i  = 1'b0;
        line_bit_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_mon();
        n_got = 0;
        n_eof = 0;
        last_aerr = 1'b0;
    endtask

    task automatic send_alt(input int n);
        for (int i = 0; i < n; i++) send_bit((i % 2) == 0);
    endtask

    task automatic carrier_off();
        idle(2);
        crs_i = 1'b0;
        idle(5);
    endtask

    // Full frame: optional broken prefix, alternating run of pre_len bits, then 1,1,
    // nbytes payload bytes LSB first, then extra trailing bits.
    task automatic frame(input string tag, input int pre_len, input bit bad_prefix,
                         input int nbytes, input int extra);
        clear_mon();
        @(negedge clk);
        crs_i = 1'b1;
        idle(2);
        if (bad_prefix) begin
            send_bit(1); send_bit(0); send_bit(1); send_bit(0); send_bit(0);
        end
        send_alt(pre_len);
        send_bit(1); send_bit(1);
        for (int k = 0; k < nbytes; k++) begin
            exp_b[k] = 8'($urandom);
            for (int j = 0; j < 8; j++) send_bit(exp_b[k][j]);
        end
        for (int j = 0; j < extra; j++) send_bit(j[0]);
        carrier_off();
        check(n_got == nbytes, {tag, " byte count R5"}, n_got, nbytes);
        for (int k = 0; k < nbytes && k < n_got; k++) begin
            check(got_b[k] == exp_b[k], {tag, " byte value LSB-first R2 R5"}, got_b[k], exp_b[k]);
            check(got_sof[k] == (k == 0), {tag, " start flag R6"}, got_sof[k], k == 0);
        end
        check(n_eof == 1, {tag, " single end pulse R7"}, n_eof, 1);
        check(last_aerr == (extra != 0), {tag, " alignment flag R7 R8"}, last_aerr, extra != 0);
    endtask

    task automatic t_reset();
        idle(1);
        check(!byte_vld_o && !sof_o && !eof_o && !align_err_o, "reset flags R1",
              {byte_vld_o, sof_o, eof_o, align_err_o}, 0);
        check(byte_o == 8'h00, "reset byte R1", byte_o, 0);
    endtask

    task automatic t_short_preamble();
        clear_mon();
        @(negedge clk);
        crs_i = 1'b1;
        idle(2);
        send_alt(6);
        send_bit(1); send_bit(1);
        for (int j = 0; j < 16; j++) send_bit(1'b0);
        carrier_off();
        check(n_got == 0, "short run gives no bytes R3", n_got, 0);
        check(n_eof == 0, "short run gives no end pulse R3", n_eof, 0);
    endtask

    task automatic t_break();
        clear_mon();
        @(negedge clk);
        crs_i = 1'b1;
        idle(2);
        send_alt(20);
        send_bit(0);
        send_bit(1); send_bit(1);
        for (int j = 0; j < 16; j++) send_bit(1'b0);
        carrier_off();
        check(n_got == 0, "double zero returns to hunt R4", n_got, 0);
        check(n_eof == 0, "double zero no end pulse R4", n_eof, 0);
    endtask

    task automatic t_no_carrier();
        clear_mon();
        crs_i = 1'b0;
        send_alt(20);
        send_bit(1); send_bit(1);
        for (int j = 0; j < 16; j++) send_bit(1'b1);
        idle(4);
        check(n_got == 0 && n_eof == 0, "strobes ignored without carrier R9", n_got + n_eof, 0);
        clear_mon();
        @(negedge clk);
        crs_i = 1'b1;
        send_alt(20);
        carrier_off();
        check(n_eof == 0, "drop before lock gives no end pulse R9", n_eof, 0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        t_reset();
        frame("full62", 62, 1'b0, 6, 0);
        frame("min8", 8, 1'b0, 3, 0);
        frame("pre20", 20, 1'b0, 4, 0);
        t_short_preamble();
        t_break();
        frame("restart", 14, 1'b1, 2, 0);
        frame("partial3", 30, 1'b0, 2, 3);
        frame("partial7", 10, 1'b0, 1, 7);
        frame("one_bit", 40, 1'b0, 0, 1);
        t_no_carrier();
        frame("again", 62, 1'b0, 5, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule